// File: doc/BRIEF.md
# DRAM Controller Configuration Register Bank

This block holds the registers that software sees when it sets up a DRAM controller. Three independent windows of 32-bit registers are provided: a common window, a controller window and a PHY window. Each window has its own select, write strobe, word address and data buses. Any register holds the value written to it and returns it on a read. Reads are combinational. Writes take effect on the rising clock edge.

A few behaviours are built on top of plain storage.

- **Bounds:** an access past the end of a window has no effect on that window's registers. A read returns zero and a write raises an error pulse.
- **PHY init handshake:** a write to the PHY-initialisation register in the controller window sets the init-done and active flags. These live in two status registers of the same window.
- **Geometry decode:** the control word of the common window is decoded into a row-address bit count, a bank-address bit count and a page size in bytes. A one-cycle load pulse tells an address-aliasing unit downstream to pick up the new geometry.

Top module: `dramcfg_regbank`

## Requirements
- R1: After reset every register of all three windows reads zero. The geometry outputs then show 1 row bit, 2 bank bits and a page size of 8 bytes.
- R2: A write to an in-range word address stores the full 32-bit value, and a later read of that address in the same window returns it. The three windows do not disturb one another.
- R3: A read whose word address is at or beyond the window's register count returns zero.
- R4: A write whose word address is at or beyond the window's register count changes no register. `oob_err` is high for exactly the one cycle after the clock edge of that write.
- R5: A write to controller word 0 stores the written value at word 0. On the same clock edge it sets bit 0 of controller word 4 (init done) and bit 0 of controller word 6 (active), and the other bits of words 4 and 6 are kept.
- R6: The init-done and active bits stay set across later cycles until reset, or until software writes those words directly. A direct write stores exactly the written value, so writing zero clears the bit.
- R7: `geo_row_bits` equals bits [7:4] of common word 0, plus 1.
- R8: `geo_bank_bits` equals bit 2 of common word 0, plus 2, so it is always 2 or 3.
- R9: `geo_page_bytes` equals 1 shifted left by (bits [11:8] of common word 0, plus 3).
- R10: `geo_load` is high for the one cycle after each write to common word 0, and the geometry outputs already show the new value in that cycle. Writes to other words never raise it.
- R11: A window's read data is zero whenever its select is low or its write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| com_sel | input | 1 | Common window select |
| com_wr | input | 1 | Common window write strobe (low = read) |
| com_addr | input | ADDR_W | Common window word address |
| com_wdata | input | 32 | Common window write data |
| com_rdata | output | 32 | Common window read data |
| ctl_sel | input | 1 | Controller window select |
| ctl_wr | input | 1 | Controller window write strobe |
| ctl_addr | input | ADDR_W | Controller window word address |
| ctl_wdata | input | 32 | Controller window write data |
| ctl_rdata | output | 32 | Controller window read data |
| phy_sel | input | 1 | PHY window select |
| phy_wr | input | 1 | PHY window write strobe |
| phy_addr | input | ADDR_W | PHY window word address |
| phy_wdata | input | 32 | PHY window write data |
| phy_rdata | output | 32 | PHY window read data |
| oob_err | output | 1 | One-cycle pulse after an out-of-range write in any window |
| geo_load | output | 1 | One-cycle pulse after a common word 0 write |
| geo_row_bits | output | 5 | Decoded row-address bit count (1 to 16) |
| geo_bank_bits | output | 2 | Decoded bank-address bit count (2 or 3) |
| geo_page_bytes | output | 19 | Decoded page size in bytes (8 to 262144) |

## Verification
The bench targets the first address past each window's end, for both reads and writes. A design with an off-by-one bound would either return stale data there or overwrite the last real register.

It preloads the status words with other bits set before triggering the init handshake. A design that assigned the flags instead of OR-ing them would lose those bits, and one that deferred the set by a cycle would show the flags late.

Control words with all-zero and all-one geometry fields expose truncated or mis-offset decoding. Back-to-back control writes, and writes to the neighbouring common word, show whether the load pulse fires once per control write and only then.

// File: rtl/dramcfg_pkg.sv
package dramcfg_pkg;

  localparam int DATA_W   = 32;
  localparam int ROW_W    = 5;
  localparam int BANK_W   = 2;
  localparam int PAGE_W   = 19;

  // field positions inside the common control word (decoded downstream)
  localparam int ROW_LSB  = 4;
  localparam int PAGE_LSB = 8;
  localparam int BANK_POS = 2;

  // controller window word indices tied to the init handshake
  localparam int PIR_IDX  = 0;
  localparam int DONE_IDX = 4;
  localparam int ACT_IDX  = 6;

  function automatic logic [ROW_W-1:0] row_bits_f(input logic [3:0] fld);
    return {1'b0, fld} + ROW_W'(1);
  endfunction

  function automatic logic [BANK_W-1:0] bank_bits_f(input logic fld);
    return BANK_W'(2) + BANK_W'(fld);
  endfunction

  function automatic logic [PAGE_W-1:0] page_bytes_f(input logic [3:0] fld);
    logic [4:0] sh;
    sh = {1'b0, fld} + 5'd3;
    return PAGE_W'(1) << sh;
  endfunction

endpackage

// File: rtl/dramcfg_window.sv
module dramcfg_window #(
  parameter int NREGS   = 8,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter bit HAS_SET = 1'b0,
  parameter int SET_A   = 0,
  parameter int SET_B   = 0,
  parameter int TAP_A   = 0,
  parameter int TAP_B   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_req,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_hit,
  output logic              oob_wr,
  output logic [NREGS-1:0]  hit_vec,
  output logic [DATA_W-1:0] tap_a,
  output logic [DATA_W-1:0] tap_b
);

  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [DATA_W-1:0] regs [NREGS];
  logic              in_range;
  logic [IDX_W-1:0]  idx;

  assign in_range = (int'(addr) < NREGS);
  assign idx      = addr[IDX_W-1:0];
  assign wr_hit   = sel & wr & in_range;
  assign oob_wr   = sel & wr & ~in_range;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    assign hit_vec[i] = wr_hit && (idx == IDX_W'(i));

    if (HAS_SET && (i == SET_A || i == SET_B)) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)
          regs[i] <= '0;
        else if (hit_vec[i])
          regs[i] <= wdata;
        else if (set_req)
          regs[i] <= regs[i] | DATA_W'(1);
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)
          regs[i] <= '0;
        else if (hit_vec[i])
          regs[i] <= wdata;
      end
    end
  end

  assign rdata = (sel && !wr && in_range) ? regs[idx] : '0;
  assign tap_a = regs[TAP_A];
  assign tap_b = regs[TAP_B];

endmodule

// File: rtl/dramcfg_geom.sv
module dramcfg_geom
  import dramcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        row_fld,
  input  logic              bank_fld,
  input  logic [3:0]        page_fld,
  input  logic              load_evt,
  output logic              geo_load,
  output logic [ROW_W-1:0]  geo_row_bits,
  output logic [BANK_W-1:0] geo_bank_bits,
  output logic [PAGE_W-1:0] geo_page_bytes
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      geo_load <= 1'b0;
    else
      geo_load <= load_evt;
  end

  assign geo_row_bits   = row_bits_f(row_fld);
  assign geo_bank_bits  = bank_bits_f(bank_fld);
  assign geo_page_bytes = page_bytes_f(page_fld);

endmodule

// File: rtl/dramcfg_regbank.sv
module dramcfg_regbank
  import dramcfg_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int COM_REGS = 8,
  parameter int CTL_REGS = 32,
  parameter int PHY_REGS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              com_sel,
  input  logic              com_wr,
  input  logic [ADDR_W-1:0] com_addr,
  input  logic [31:0]       com_wdata,
  output logic [31:0]       com_rdata,
  input  logic              ctl_sel,
  input  logic              ctl_wr,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  input  logic              phy_sel,
  input  logic              phy_wr,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [31:0]       phy_wdata,
  output logic [31:0]       phy_rdata,
  output logic              oob_err,
  output logic              geo_load,
  output logic [4:0]        geo_row_bits,
  output logic [1:0]        geo_bank_bits,
  output logic [18:0]       geo_page_bytes
);

  // named internal events (observed by the bound checker)
  logic              ctrl_wr_hit;
  logic              pir_hit;
  logic              stat_wr_hit;
  logic              any_oob;
  logic              ctl_done_bit;
  logic              ctl_act_bit;

  logic              com_hit, ctl_hit, phy_hit;
  logic              com_oob, ctl_oob, phy_oob;
  logic [COM_REGS-1:0] com_hv;
  logic [CTL_REGS-1:0] ctl_hv;
  logic [PHY_REGS-1:0] phy_hv;
  logic [31:0]       com_ctrl_word, com_tap_unused;
  logic [31:0]       ctl_done_word, ctl_act_word;
  logic [31:0]       phy_tap_a, phy_tap_b;

  dramcfg_window #(
    .NREGS(COM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .HAS_SET(1'b0), .SET_A(0), .SET_B(0), .TAP_A(0), .TAP_B(0)
  ) u_com (
    .clk(clk), .rst_n(rst_n), .sel(com_sel), .wr(com_wr), .addr(com_addr),
    .wdata(com_wdata), .set_req(1'b0), .rdata(com_rdata), .wr_hit(com_hit),
    .oob_wr(com_oob), .hit_vec(com_hv), .tap_a(com_ctrl_word),
    .tap_b(com_tap_unused)
  );

  dramcfg_window #(
    .NREGS(CTL_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .HAS_SET(1'b1), .SET_A(DONE_IDX), .SET_B(ACT_IDX),
    .TAP_A(DONE_IDX), .TAP_B(ACT_IDX)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .sel(ctl_sel), .wr(ctl_wr), .addr(ctl_addr),
    .wdata(ctl_wdata), .set_req(pir_hit), .rdata(ctl_rdata), .wr_hit(ctl_hit),
    .oob_wr(ctl_oob), .hit_vec(ctl_hv), .tap_a(ctl_done_word),
    .tap_b(ctl_act_word)
  );

  dramcfg_window #(
    .NREGS(PHY_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .HAS_SET(1'b0), .SET_A(0), .SET_B(0), .TAP_A(0), .TAP_B(0)
  ) u_phy (
    .clk(clk), .rst_n(rst_n), .sel(phy_sel), .wr(phy_wr), .addr(phy_addr),
    .wdata(phy_wdata), .set_req(1'b0), .rdata(phy_rdata), .wr_hit(phy_hit),
    .oob_wr(phy_oob), .hit_vec(phy_hv), .tap_a(phy_tap_a), .tap_b(phy_tap_b)
  );

  assign ctrl_wr_hit  = com_hv[0];
  assign pir_hit      = ctl_hv[PIR_IDX];
  assign stat_wr_hit  = ctl_hv[DONE_IDX] | ctl_hv[ACT_IDX];
  assign any_oob      = com_oob | ctl_oob | phy_oob;
  assign ctl_done_bit = ctl_done_word[0];
  assign ctl_act_bit  = ctl_act_word[0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      oob_err <= 1'b0;
    else
      oob_err <= any_oob;
  end

  dramcfg_geom u_geom (
    .clk(clk), .rst_n(rst_n),
    .row_fld(com_ctrl_word[ROW_LSB +: 4]),
    .bank_fld(com_ctrl_word[BANK_POS]),
    .page_fld(com_ctrl_word[PAGE_LSB +: 4]),
    .load_evt(ctrl_wr_hit),
    .geo_load(geo_load), .geo_row_bits(geo_row_bits),
    .geo_bank_bits(geo_bank_bits), .geo_page_bytes(geo_page_bytes)
  );

endmodule

// File: rtl/dramcfg_chk.sv
module dramcfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pir_hit,
  input logic        stat_wr_hit,
  input logic        ctrl_wr_hit,
  input logic        any_oob,
  input logic        ctl_done_bit,
  input logic        ctl_act_bit,
  input logic        oob_err,
  input logic        geo_load,
  input logic        com_sel,
  input logic [31:0] com_rdata,
  input logic [1:0]  geo_bank_bits,
  input logic [18:0] geo_page_bytes
);

  AST_PIR_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    pir_hit |=> (ctl_done_bit && ctl_act_bit)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_done_bit && !stat_wr_hit) |=> ctl_done_bit); // R6

  AST_OOB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    any_oob |=> oob_err); // R4

  AST_OOB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    oob_err |-> $past(any_oob)); // R4

  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    geo_load |-> $past(ctrl_wr_hit)); // R10

  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_hit |=> geo_load); // R10

  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    geo_bank_bits[1]); // R8

  AST_PAGE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(geo_page_bytes) == 1); // R9

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !com_sel |-> (com_rdata == 32'd0)); // R11

endmodule

bind dramcfg_regbank dramcfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pir_hit(pir_hit), .stat_wr_hit(stat_wr_hit),
  .ctrl_wr_hit(ctrl_wr_hit), .any_oob(any_oob), .ctl_done_bit(ctl_done_bit),
  .ctl_act_bit(ctl_act_bit), .oob_err(oob_err), .geo_load(geo_load),
  .com_sel(com_sel), .com_rdata(com_rdata), .geo_bank_bits(geo_bank_bits),
  .geo_page_bytes(geo_page_bytes)
);

// File: tb/dramcfg_regbank_tb.sv
`timescale 1ns/1ps
module dramcfg_regbank_tb;

  localparam int AW = 10;
  localparam int NC = 8, NT = 32, NP = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0]    sel;
  logic [2:0]    wr;
  logic [AW-1:0] addr [3];
  logic [31:0]   wd   [3];
  logic [31:0]   rd   [3];
  logic oob_err, geo_load;
  logic [4:0] row_o; logic [1:0] bank_o; logic [18:0] page_o;

  always #2 clk = ~clk;

  dramcfg_regbank u_dut (
    .clk(clk), .rst_n(rst_n),
    .com_sel(sel[0]), .com_wr(wr[0]), .com_addr(addr[0]), .com_wdata(wd[0]), .com_rdata(rd[0]),
    .ctl_sel(sel[1]), .ctl_wr(wr[1]), .ctl_addr(addr[1]), .ctl_wdata(wd[1]), .ctl_rdata(rd[1]),
    .phy_sel(sel[2]), .phy_wr(wr[2]), .phy_addr(addr[2]), .phy_wdata(wd[2]), .phy_rdata(rd[2]),
    .oob_err(oob_err), .geo_load(geo_load), .geo_row_bits(row_o),
    .geo_bank_bits(bank_o), .geo_page_bytes(page_o)
  );

  // behavioural reference
  int unsigned mem [3][$];
  int          exp_oob, exp_load;
  int          checks = 0, failures = 0;
  bit          done = 0;

  function automatic int wsize(int w);
    return (w == 0) ? NC : (w == 1) ? NT : NP;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of registered outputs against the model
  task automatic check_state(string req);
    int unsigned c;
    c = mem[0][0];
    chk(req, "oob_err", oob_err, exp_oob);
    chk(req, "geo_load", geo_load, exp_load);
    chk("R7", "row_bits", row_o, (c / 16) % 16 + 1);
    chk("R8", "bank_bits", bank_o, ((c / 4) % 2) + 2);
    chk("R9", "page_bytes", page_o, 64'd1 << ((c / 256) % 16 + 3));
  endtask

  // one bus cycle; w<0 means idle
  task automatic step(int w, bit is_wr, int a, int unsigned d, string req);
    @(negedge clk);
    check_state(req);
    sel = '0; wr = '0;
    for (int k = 0; k < 3; k++) begin addr[k] = '0; wd[k] = '0; end
    if (w >= 0) begin
      sel[w] = 1'b1; wr[w] = is_wr; addr[w] = AW'(a); wd[w] = d;
    end
    #1;
    for (int k = 0; k < 3; k++) begin
      longint e;
      e = 0;
      if (k == w && !is_wr && a < wsize(k)) e = mem[k][a];
      chk((k == w && !is_wr) ? req : "R11", $sformatf("rdata[%0d]@%0d", k, a), rd[k], e);
    end
    @(posedge clk);
    exp_oob = 0; exp_load = 0;
    if (w >= 0 && is_wr) begin
      if (a < wsize(w)) begin
        if (w == 1 && a == 0) begin mem[1][4] |= 1; mem[1][6] |= 1; end
        mem[w][a] = d;
        if (w == 0 && a == 0) exp_load = 1;
      end else exp_oob = 1;
    end
  endtask

  task automatic rd_all(int w, string req);
    for (int i = 0; i < wsize(w); i++) step(w, 0, i, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) for (int i = 0; i < wsize(k); i++) mem[k].push_back(0);
    exp_oob = 0; exp_load = 0;
    sel = '0; wr = '0;
    for (int k = 0; k < 3; k++) begin addr[k] = '0; wd[k] = '0; end
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    // R1: reset state in all windows, default geometry
    for (int k = 0; k < 3; k++) rd_all(k, "R1");
    // R2: storage and window independence
    step(0, 1, 3, 32'hDEAD_BEEF, "R2");
    step(1, 1, 3, 32'h1234_5678, "R2");
    step(2, 1, 3, 32'hA5A5_5A5A, "R2");
    step(2, 1, NP - 1, 32'hFFFF_FFFF, "R2");
    step(1, 1, NT - 1, 32'h0000_0001, "R2");
    for (int k = 0; k < 3; k++) step(k, 0, 3, 0, "R2");
    step(2, 0, NP - 1, 0, "R2");
    step(1, 0, NT - 1, 0, "R2");
    // R3: reads past the end
    step(0, 0, NC, 0, "R3");
    step(1, 0, NT, 0, "R3");
    step(2, 0, (1 << AW) - 1, 0, "R3");
    // R4: writes past the end are dropped
    step(2, 1, NP, 32'h7777_7777, "R4");
    step(0, 1, NC, 32'h0000_0FF4, "R4");
    step(1, 1, 1000, 32'h5555_5555, "R4");
    step(-1, 0, 0, 0, "R4");
    rd_all(2, "R4");
    rd_all(0, "R4");
    // R5: init handshake keeps other status bits
    step(1, 1, 4, 32'h0000_0050, "R5");
    step(1, 1, 6, 32'h8000_0000, "R5");
    step(1, 1, 0, 32'hABCD_0000, "R5");
    step(1, 0, 4, 0, "R5");
    step(1, 0, 6, 0, "R5");
    step(1, 0, 0, 0, "R5");
    // R6: flags persist, direct write clears
    repeat (5) step(-1, 0, 0, 0, "R6");
    step(1, 0, 4, 0, "R6");
    step(1, 1, 4, 0, "R6");
    step(1, 0, 4, 0, "R6");
    step(1, 0, 6, 0, "R6");
    step(1, 1, 0, 32'h0, "R6");
    step(1, 0, 4, 0, "R6");
    // R7-R10: geometry decode and load pulse
    step(0, 1, 0, 32'h0000_0FFF, "R10");
    step(0, 1, 0, 32'h0000_0000, "R10");
    step(0, 1, 0, 32'h0000_0A74, "R10");
    step(0, 1, 1, 32'h0000_0FFF, "R10");
    step(-1, 0, 0, 0, "R10");
    step(0, 1, 0, 32'hFFFF_F0FB, "R10");
    step(0, 0, 0, 0, "R10");
    step(0, 1, 0, 32'h0000_05B0, "R10");
    // R11: reads while writing or deselected
    step(2, 1, 5, 32'h0BAD_F00D, "R11");
    step(2, 0, 5, 0, "R11");
    step(-1, 0, 0, 0, "R11");
    // R1: reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    for (int k = 0; k < 3; k++) for (int i = 0; i < wsize(k); i++) mem[k][i] = 0;
    exp_oob = 0; exp_load = 0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 3; k++) rd_all(k, "R1");
    step(-1, 0, 0, 0, "R1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule